// File: doc/BRIEF.md
# Read-Protection Access Arbiter

This block holds the chip's read-protection field and sits between every requester and the internal flash and backup SRAM. It decodes the field into one of three levels: open, locked and sealed. For each access it decides whether the read, write or erase may pass on to the memory, using the level and the requester. The requester is a CPU that booted from flash, a CPU that booted from SRAM or system memory, or the debug port. The block also reports whether the debug interface and booting from SRAM are still allowed.

Software asks for a new level by presenting a new field value. The block accepts the request only from states that permit it. When the request lowers protection from locked to open, the block first runs a mass erase through a handshake with the erase engine. It then writes the new field through a handshake with the option storage. The new level takes effect once that write has finished. The flash array, the erase engine and the option storage are outside the block. Each is reached through a request/done pair or a forwarded access strobe.

Top module: `rdp_access_arbiter`

## Requirements
- R1: The field decodes to a level on `curLevel` (0 open, 1 locked, 2 sealed): the value 0xAA gives 0, 0xCC gives 2 and any other value gives 1. While `rst_n` is low, `curLevel` follows `storedField` combinationally. The value present at the last reset clock is kept as the current field.
- R2: At level 0, every source (0 flash-booted CPU, 1 SRAM/system-booted CPU, 2 debug port, 3 reserved) is granted read, write and erase.
- R3: At levels 1 and 2, only source 0 is granted. Sources 1, 2 and 3 are denied, and `memReq` stays low for them.
- R4: Op codes are 0 read, 1 write, 2 erase and 3 reserved. A reserved op is denied at every level. A denied request makes `rspValid` and `rspErr` pulse high for one cycle, one clock after the request, with `rspData` zero.
- R5: A granted request asserts `memReq` in the same cycle. One clock later `rspValid` pulses with `rspErr` low. `rspData` equals the `memRdData` sampled with a read request, and is zero for a write or an erase.
- R6: A level change request is accepted only when no change is in progress, `engBusy` is low and the level is not 2. One clock after the request, `chgAck` pulses if it was accepted and `chgErr` pulses otherwise.
- R7: An accepted change from level 1 to a level-0 value raises `eraseReq` and holds it until `eraseDone`. The level stays 1 until then.
- R8: After the erase, and directly for other changes, `optWrReq` is held with `optWrData` equal to the requested field until `optWrDone`. The new level appears on the clock that samples `optWrDone`.
- R9: At level 2, `dbgEnable` and `sramBootOk` are low, and no request or handshake input moves the level away from 2. At other levels both flags are high.
- R10: An accepted change that is not level 1 to level 0 goes straight to the option write, and `eraseReq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| storedField | input | FW | Field value held in option storage |
| accValid | input | 1 | Access request strobe |
| accOp | input | 2 | Access kind: 0 read, 1 write, 2 erase, 3 reserved |
| accSource | input | 2 | Requester: 0 flash CPU, 1 SRAM CPU, 2 debug, 3 reserved |
| memRdData | input | DW | Read data returned by the array |
| memReq | output | 1 | Granted access forwarded to the array |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Response was a denial |
| rspData | output | DW | Response read data, zero unless a granted read |
| chgValid | input | 1 | Level change request |
| chgField | input | FW | Requested field value |
| engBusy | input | 1 | Erase/program engine busy |
| eraseDone | input | 1 | Mass erase finished |
| optWrDone | input | 1 | Option write finished |
| chgAck | output | 1 | Change accepted pulse |
| chgErr | output | 1 | Change rejected pulse |
| eraseReq | output | 1 | Mass erase request, held until done |
| optWrReq | output | 1 | Option write request, held until done |
| optWrData | output | FW | Field value to write |
| curLevel | output | 2 | Current protection level |
| dbgEnable | output | 1 | Debug interface allowed |
| sramBootOk | output | 1 | Boot from SRAM/system memory allowed |

## Verification
The bench builds the block with a 16-bit data path and the default 8-bit field and level codes. The narrower data bus keeps the read values distinct from the field codes, so a response that carries a field value instead of the read data shows up as a mismatch. The codes 0xAA and 0xCC, together with two arbitrary locked-level values, reach every level and every legal and illegal transition. This includes the erase-guarded downgrade and the attempts to leave level 2.

// File: rtl/rdp_arb_pkg.sv
package rdp_arb_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_LOCKED = 2'd1,
    LVL_SEALED = 2'd2
  } protLevel_e;

  typedef enum logic [1:0] {
    SRC_FLASH_CPU = 2'd0,
    SRC_RAM_CPU   = 2'd1,
    SRC_DEBUG     = 2'd2,
    SRC_RSVD      = 2'd3
  } reqSource_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } accOp_e;

  // strobes from control to datapath
  typedef struct packed {
    protLevel_e level;
    logic       openAll;
  } ctrlStrobes_t;

endpackage

// File: rtl/rdp_arb_ctrl.sv
module rdp_arb_ctrl
  import rdp_arb_pkg::*;
#(
  parameter int FW = 8,
  parameter logic [FW-1:0] OPEN_CODE = FW'('hAA),
  parameter logic [FW-1:0] SEAL_CODE = FW'('hCC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] storedField,
  input  logic          chgValid,
  input  logic [FW-1:0] chgField,
  input  logic          engBusy,
  input  logic          eraseDone,
  input  logic          optWrDone,
  output logic          eraseReq,
  output logic          optWrReq,
  output logic [FW-1:0] optWrData,
  output logic          chgAck,
  output logic          chgErr,
  output ctrlStrobes_t  strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} chgState_e;

  chgState_e     stQ;
  logic [FW-1:0] fieldQ;
  logic [FW-1:0] pendQ;
  protLevel_e    levelNow;
  logic          chgOk;
  logic          needsErase;

  function automatic protLevel_e decodeField(input logic [FW-1:0] f);
    if (f == OPEN_CODE)      return LVL_OPEN;
    else if (f == SEAL_CODE) return LVL_SEALED;
    else                     return LVL_LOCKED;
  endfunction

  // R1: level follows storage combinationally while in reset
  always_comb begin
    levelNow   = decodeField(rst_n ? fieldQ : storedField);
    chgOk      = chgValid && (stQ == ST_IDLE) && !engBusy && (levelNow != LVL_SEALED);
    needsErase = (levelNow == LVL_LOCKED) && (decodeField(chgField) == LVL_OPEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fieldQ <= storedField;
      pendQ  <= '0;
      stQ    <= ST_IDLE;
      chgAck <= 1'b0;
      chgErr <= 1'b0;
    end else begin
      chgAck <= chgOk;
      chgErr <= chgValid && !chgOk;
      unique case (stQ)
        ST_IDLE: if (chgOk) begin
          pendQ <= chgField;
          stQ   <= needsErase ? ST_ERASE : ST_PROG;
        end
        ST_ERASE: if (eraseDone) stQ <= ST_PROG;
        ST_PROG: if (optWrDone) begin
          fieldQ <= pendQ;
          stQ    <= ST_IDLE;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  assign eraseReq        = (stQ == ST_ERASE);
  assign optWrReq        = (stQ == ST_PROG);
  assign optWrData       = pendQ;
  assign strobes.level   = levelNow;
  assign strobes.openAll = (levelNow == LVL_OPEN);

  assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (levelNow == LVL_SEALED) |=> (levelNow == LVL_SEALED));

  assert_erase_from_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> (levelNow == LVL_LOCKED));

  assert_level_held_in_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |=> (levelNow == LVL_LOCKED));

  assert_ack_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chgAck |-> (!$past(engBusy) && ($past(levelNow) != LVL_SEALED)));

  assert_ack_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(chgAck && chgErr));

endmodule

// File: rtl/rdp_arb_datapath.sv
module rdp_arb_datapath
  import rdp_arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobes_t  strobes,
  input  logic          accValid,
  input  logic [1:0]    accOp,
  input  logic [1:0]    accSource,
  input  logic [DW-1:0] memRdData,
  output logic          memReq,
  output logic          rspValid,
  output logic          rspErr,
  output logic [DW-1:0] rspData,
  output logic          dbgEnable,
  output logic          sramBootOk
);

  accOp_e     opNow;
  reqSource_e srcNow;
  logic       granted;

  always_comb begin
    opNow   = accOp_e'(accOp);
    srcNow  = reqSource_e'(accSource);
    granted = (strobes.openAll || (srcNow == SRC_FLASH_CPU)) && (opNow != OP_RSVD);
  end

  assign memReq = accValid && granted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= accValid;
      rspErr   <= accValid && !granted;
      rspData  <= (memReq && (opNow == OP_READ)) ? memRdData : '0;
    end
  end

  assign dbgEnable  = (strobes.level != LVL_SEALED);
  assign sramBootOk = (strobes.level != LVL_SEALED);

  assert_denied_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rspErr |-> (rspData == '0));

  assert_err_is_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rspErr |-> rspValid);

  assert_locked_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && (strobes.level != LVL_OPEN)) |-> (accSource == 2'd0));

  assert_open_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && (strobes.level == LVL_OPEN) && (accOp != 2'd3)) |-> memReq);

endmodule

// File: rtl/rdp_access_arbiter.sv
module rdp_access_arbiter
  import rdp_arb_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 8,
  parameter logic [FW-1:0] OPEN_CODE = FW'('hAA),
  parameter logic [FW-1:0] SEAL_CODE = FW'('hCC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] storedField,
  input  logic          accValid,
  input  logic [1:0]    accOp,
  input  logic [1:0]    accSource,
  input  logic [DW-1:0] memRdData,
  output logic          memReq,
  output logic          rspValid,
  output logic          rspErr,
  output logic [DW-1:0] rspData,
  input  logic          chgValid,
  input  logic [FW-1:0] chgField,
  input  logic          engBusy,
  input  logic          eraseDone,
  input  logic          optWrDone,
  output logic          chgAck,
  output logic          chgErr,
  output logic          eraseReq,
  output logic          optWrReq,
  output logic [FW-1:0] optWrData,
  output logic [1:0]    curLevel,
  output logic          dbgEnable,
  output logic          sramBootOk
);

  ctrlStrobes_t strobes;

  rdp_arb_ctrl #(.FW(FW), .OPEN_CODE(OPEN_CODE), .SEAL_CODE(SEAL_CODE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .storedField(storedField),
    .chgValid(chgValid), .chgField(chgField), .engBusy(engBusy),
    .eraseDone(eraseDone), .optWrDone(optWrDone),
    .eraseReq(eraseReq), .optWrReq(optWrReq), .optWrData(optWrData),
    .chgAck(chgAck), .chgErr(chgErr), .strobes(strobes)
  );

  rdp_arb_datapath #(.DW(DW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .accValid(accValid), .accOp(accOp), .accSource(accSource),
    .memRdData(memRdData), .memReq(memReq),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .dbgEnable(dbgEnable), .sramBootOk(sramBootOk)
  );

  assign curLevel = strobes.level;

endmodule

// File: tb/rdp_access_arbiter_tb.sv
`timescale 1ns/1ps
module rdp_access_arbiter_tb_top;

  localparam int DW = 16;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0] storedField = 8'hAA;
  logic accValid = 0;
  logic [1:0] accOp = 0, accSource = 0;
  logic [DW-1:0] memRdData = 0;
  logic memReq, rspValid, rspErr;
  logic [DW-1:0] rspData;
  logic chgValid = 0;
  logic [FW-1:0] chgField = 0;
  logic engBusy = 0, eraseDone = 0, optWrDone = 0;
  logic chgAck, chgErr, eraseReq, optWrReq;
  logic [FW-1:0] optWrData;
  logic [1:0] curLevel;
  logic dbgEnable, sramBootOk;

  always #2.5 clk = ~clk;

  rdp_access_arbiter #(.DW(DW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .storedField(storedField),
    .accValid(accValid), .accOp(accOp), .accSource(accSource),
    .memRdData(memRdData), .memReq(memReq),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .chgValid(chgValid), .chgField(chgField), .engBusy(engBusy),
    .eraseDone(eraseDone), .optWrDone(optWrDone),
    .chgAck(chgAck), .chgErr(chgErr), .eraseReq(eraseReq),
    .optWrReq(optWrReq), .optWrData(optWrData),
    .curLevel(curLevel), .dbgEnable(dbgEnable), .sramBootOk(sramBootOk)
  );

  int errs = 0;
  int checks = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lvlOf(input logic [FW-1:0] f);
    if (f == 8'hAA) return 0;
    if (f == 8'hCC) return 2;
    return 1;
  endfunction

  // behavioural reference model
  int fieldM = 0, pendM = 0, stM = 0;
  bit expRspV = 0, expRspE = 0, expAck = 0, expErr = 0;
  int expRspD = 0;

  always @(posedge clk) begin
    int lvl;
    bit grant, ok;
    if (!rst_n) begin
      fieldM = storedField; pendM = 0; stM = 0;
      expRspV = 0; expRspE = 0; expRspD = 0; expAck = 0; expErr = 0;
    end else begin
      lvl = lvlOf(fieldM[7:0]);
      grant = accValid && (lvl == 0 || accSource == 0) && accOp != 3;
      expRspV = accValid;
      expRspE = accValid && !grant;
      expRspD = (grant && accOp == 0) ? int'(memRdData) : 0;
      ok = chgValid && stM == 0 && !engBusy && lvl != 2;
      expAck = ok;
      expErr = chgValid && !ok;
      case (stM)
        0: if (ok) begin
             pendM = chgField;
             stM = (lvl == 1 && lvlOf(chgField) == 0) ? 1 : 2;
           end
        1: if (eraseDone) stM = 2;
        default: if (optWrDone) begin fieldM = pendM; stM = 0; end
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int lvl;
    if (rst_n) begin
      lvl = lvlOf(fieldM[7:0]);
      chk(curLevel == lvl, "R1", "curLevel", curLevel, lvl);
      chk(dbgEnable == (lvl != 2), "R9", "dbgEnable", dbgEnable, lvl != 2);
      chk(sramBootOk == (lvl != 2), "R9", "sramBootOk", sramBootOk, lvl != 2);
      chk(memReq == (accValid && (lvl == 0 || accSource == 0) && accOp != 3),
          "R3", "memReq", memReq, accValid && (lvl == 0 || accSource == 0) && accOp != 3);
      chk(rspValid == expRspV, "R5", "rspValid", rspValid, expRspV);
      chk(rspErr == expRspE, "R4", "rspErr", rspErr, expRspE);
      chk(int'(rspData) == expRspD, "R5", "rspData", rspData, expRspD);
      chk(chgAck == expAck, "R6", "chgAck", chgAck, expAck);
      chk(chgErr == expErr, "R6", "chgErr", chgErr, expErr);
      chk(eraseReq == (stM == 1), "R7", "eraseReq", eraseReq, stM == 1);
      chk(optWrReq == (stM == 2), "R8", "optWrReq", optWrReq, stM == 2);
      if (stM == 2)
        chk(int'(optWrData) == pendM, "R8", "optWrData", optWrData, pendM);
    end
  end

  task automatic doAcc(input int src, input int op, input int data,
                       input bit eErr, input int eData, input string tag);
    accValid = 1; accSource = 2'(src); accOp = 2'(op); memRdData = DW'(data);
    @(posedge clk); #1 accValid = 0;
    @(negedge clk);
    chk(rspValid == 1, tag, "rspValid", rspValid, 1);
    chk(rspErr == eErr, tag, "rspErr", rspErr, eErr);
    chk(int'(rspData) == eData, tag, "rspData", rspData, eData);
    @(posedge clk); #1;
  endtask

  task automatic doChg(input logic [FW-1:0] f, input bit eAck, input string tag);
    chgValid = 1; chgField = f;
    @(posedge clk); #1 chgValid = 0;
    @(negedge clk);
    chk(chgAck == eAck, tag, "chgAck", chgAck, eAck);
    chk(chgErr == !eAck, tag, "chgErr", chgErr, !eAck);
    @(posedge clk); #1;
  endtask

  task automatic pulseErase();
    eraseDone = 1; @(posedge clk); #1 eraseDone = 0; @(negedge clk);
  endtask

  task automatic pulseOpt();
    optWrDone = 1; @(posedge clk); #1 optWrDone = 0; @(negedge clk);
  endtask

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cycles);
      finishUp();
    end
  end

  initial begin
    // R1: reset-time decode follows the stored field combinationally
    #1 chk(curLevel == 0, "R1", "reset level AA", curLevel, 0);
    storedField = 8'hCC; #1;
    chk(curLevel == 2, "R1", "reset level CC", curLevel, 2);
    chk(dbgEnable == 0, "R9", "reset dbgEnable", dbgEnable, 0);
    storedField = 8'h3C; #1;
    chk(curLevel == 1, "R1", "reset level 3C", curLevel, 1);
    storedField = 8'h5A; #1;
    chk(sramBootOk == 1, "R9", "reset sramBootOk", sramBootOk, 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rspValid == 0 && chgAck == 0 && eraseReq == 0 && optWrReq == 0,
        "R6", "idle after reset", {rspValid, chgAck, eraseReq, optWrReq}, 0);
    @(posedge clk); #1;

    // level 1 access rules
    doAcc(0, 0, 16'h1234, 0, 16'h1234, "R3");
    doAcc(1, 0, 16'hBEEF, 1, 0, "R3");
    doAcc(2, 1, 16'h5555, 1, 0, "R4");
    doAcc(0, 2, 16'h7777, 0, 0, "R5");
    doAcc(0, 3, 16'h4321, 1, 0, "R4");
    doAcc(3, 0, 16'h1111, 1, 0, "R3");

    // downgrade 1 -> 0
    engBusy = 1;
    doChg(8'hAA, 0, "R6");
    engBusy = 0;
    doChg(8'hAA, 1, "R6");
    chk(eraseReq == 1, "R7", "erase raised", eraseReq, 1);
    chk(curLevel == 1, "R7", "level during erase", curLevel, 1);
    doAcc(2, 0, 16'h2222, 1, 0, "R7");
    doChg(8'hCC, 0, "R6");
    pulseErase();
    chk(eraseReq == 0 && optWrReq == 1, "R8", "erase->prog", {eraseReq, optWrReq}, 1);
    chk(optWrData == 8'hAA, "R8", "optWrData", optWrData, 8'hAA);
    chk(curLevel == 1, "R8", "level before write done", curLevel, 1);
    pulseOpt();
    chk(curLevel == 0, "R8", "level after write", curLevel, 0);
    @(posedge clk); #1;

    // level 0: everyone granted
    doAcc(2, 0, 16'h0F0F, 0, 16'h0F0F, "R2");
    doAcc(1, 1, 16'h3333, 0, 0, "R2");
    doAcc(2, 2, 16'h4444, 0, 0, "R2");

    // 0 -> 1 without erase
    doChg(8'h77, 1, "R10");
    chk(eraseReq == 0 && optWrReq == 1, "R10", "no erase on raise", {eraseReq, optWrReq}, 1);
    pulseOpt();
    chk(curLevel == 1, "R10", "level raised", curLevel, 1);
    @(posedge clk); #1;

    // 1 -> 2
    doChg(8'hCC, 1, "R10");
    chk(eraseReq == 0, "R10", "no erase on seal", eraseReq, 0);
    pulseOpt();
    chk(curLevel == 2, "R9", "sealed", curLevel, 2);
    chk(dbgEnable == 0 && sramBootOk == 0, "R9", "flags sealed", {dbgEnable, sramBootOk}, 0);
    @(posedge clk); #1;
    doChg(8'hAA, 0, "R9");
    doChg(8'h55, 0, "R9");
    doAcc(2, 0, 16'h9999, 1, 0, "R9");
    doAcc(1, 1, 16'h9999, 1, 0, "R3");
    doAcc(0, 0, 16'hCAFE, 0, 16'hCAFE, "R3");
    pulseErase();
    pulseOpt();
    chk(curLevel == 2, "R9", "sealed after stray done", curLevel, 2);
    repeat (3) @(posedge clk);
    finishUp();
  end

endmodule